// File: doc/BRIEF.md
# Sixteen-bit ALU with excess-word register

The block is the execute stage of a small 16-bit processor. A 5-bit operation code, a destination operand `b` and a source operand `a` go in. The block returns the new value for `b` and a flag for the compare operations. It also returns the value that the excess word (EX) would take, together with a write enable for EX. All of these outputs are combinational and follow the inputs in the same cycle.

EX is a full 16-bit word, not a single carry bit, and it sits in a register inside the block. What EX holds depends on the operation:
- the carry out of an add, or a borrow mask after a subtract;
- the upper half of a product;
- the fraction of a quotient;
- the bits pushed out by a shift.

The two carry-in forms read the current EX. Operand fetch, memory access and the skip of the following instruction after a false compare are left to the surrounding pipeline.

Top module: `ex_alu16`

## Requirements
- R1: After reset, the excess word `ex_o` reads 0x0000.
- R2: Code 0x02 returns b+a, with EX next = 0x0001 on unsigned carry out and 0x0000 otherwise. Code 0x03 returns b-a, with EX next = 0xFFFF when a>b and 0x0000 otherwise.
- R3: Code 0x04 (unsigned) and code 0x05 (signed) multiply. The result is bits 15:0 of the 32-bit product and EX next is bits 31:16.
- R4: Code 0x06 (unsigned) and code 0x07 (signed, rounding toward zero) divide. The result is b/a and EX next is the low 16 bits of (b·65536)/a. When a is 0, both the result and EX next are 0.
- R5: Code 0x08 (unsigned) and code 0x09 (signed, sign follows b) give the remainder b%a. The result is 0 when a is 0, and EX is not written.
- R6: Codes 0x0A, 0x0B and 0x0C return b AND a, b OR a and b XOR a. EX is left unchanged.
- R7: Code 0x0D shifts right logically, code 0x0E shifts right arithmetically and code 0x0F shifts left, each by the amount a. EX next is the other half of the 32-bit shift of b: for a right shift, b placed in the upper half, and for a left shift, b placed in the lower half. Amounts of 16 or more give 0, or the sign fill for code 0x0E.
- R8: Code 0x1A returns b+a+EX, with EX next = 0x0001 when the sum exceeds 0xFFFF and 0x0000 otherwise. Code 0x1B returns b-a+EX, with EX next = 0xFFFF when that value is negative and 0x0000 otherwise.
- R9: Codes 0x10 to 0x17 return b unchanged and do not write EX. `cond_o` is set by the following conditions:
  - 0x10: (b&a)!=0
  - 0x11: (b&a)==0
  - 0x12: b==a
  - 0x13: b!=a
  - 0x14: b>a unsigned
  - 0x15: b>a signed
  - 0x16: b<a unsigned
  - 0x17: b<a signed

  `cond_o` is 0 for every other code.
- R10: Codes 0x00, 0x18, 0x19, 0x1C and 0x1D return b unchanged. Codes 0x01, 0x1E and 0x1F return a. None of these codes writes EX.
- R11: `ex_we_o` is high only when `exec_i` is high and the code is one of 0x02 to 0x07, 0x0D to 0x0F, 0x1A or 0x1B. EX takes `ex_next_o` on a rising clock edge where `ex_we_o` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears EX |
| exec_i | input | 1 | Execute strobe; gates the EX write |
| op_i | input | 5 | Operation code |
| b_i | input | 16 | Destination operand b |
| a_i | input | 16 | Source operand a (also the shift amount) |
| res_o | output | 16 | New value for b |
| ex_next_o | output | 16 | Value EX takes if written |
| ex_we_o | output | 1 | EX write enable |
| cond_o | output | 1 | Compare condition true |
| ex_o | output | 16 | Current EX value |

## Verification
`res_o`, `cond_o`, `ex_we_o` and `ex_next_o` are combinational. They are due in the same cycle that the operation and operands are applied. The bench drives inputs on the falling edge and samples these four outputs 1 ns later, well before the next rising edge. `ex_o` changes only at the rising edge that follows an enabled operation, so it is sampled 1 ns after that edge. Before each table vector, an enabled 0-0 subtract clears EX. This lets the carry-in operations and the "EX unchanged" cases be judged against a known EX.

// File: rtl/ex_alu_pkg.sv
package ex_alu_pkg;
  localparam int OPW = 5;
  typedef logic [OPW-1:0] op_t;

  localparam op_t OP_HOLD0   = 5'h00;
  localparam op_t OP_COPY    = 5'h01;
  localparam op_t OP_ADD     = 5'h02;
  localparam op_t OP_SUB     = 5'h03;
  localparam op_t OP_MULU    = 5'h04;
  localparam op_t OP_MULS    = 5'h05;
  localparam op_t OP_DIVU    = 5'h06;
  localparam op_t OP_DIVS    = 5'h07;
  localparam op_t OP_REMU    = 5'h08;
  localparam op_t OP_REMS    = 5'h09;
  localparam op_t OP_AND     = 5'h0A;
  localparam op_t OP_OR      = 5'h0B;
  localparam op_t OP_XOR     = 5'h0C;
  localparam op_t OP_SRL     = 5'h0D;
  localparam op_t OP_SRA     = 5'h0E;
  localparam op_t OP_SLL     = 5'h0F;
  localparam op_t OP_ADDX    = 5'h1A;
  localparam op_t OP_SUBX    = 5'h1B;
  localparam op_t OP_COPY_UP = 5'h1E;
  localparam op_t OP_COPY_DN = 5'h1F;

  // Codes whose result updates the excess word.
  function automatic logic op_writes_ex(op_t op);
    case (op)
      OP_ADD, OP_SUB, OP_MULU, OP_MULS, OP_DIVU, OP_DIVS,
      OP_SRL, OP_SRA, OP_SLL, OP_ADDX, OP_SUBX: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_compare(op_t op);
    return op[OPW-1:OPW-2] == 2'b10;
  endfunction
endpackage

// File: rtl/ex_alu_addsub.sv
module ex_alu_addsub #(
  parameter int W = 16
) (
  input  logic         sub_i,
  input  logic         use_ex_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] ex_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] ex_o
);
  localparam int SW = W + 2;

  logic [SW-1:0] b_x, a_x, c_x, acc;
  logic          carry_out, went_negative;

  assign b_x = {2'b00, b_i};
  assign a_x = {2'b00, a_i};
  assign c_x = use_ex_i ? {2'b00, ex_i} : '0;
  assign acc = sub_i ? (b_x - a_x + c_x) : (b_x + a_x + c_x);

  assign carry_out     = |acc[SW-1:W];
  assign went_negative = acc[SW-1];

  assign res_o = acc[W-1:0];
  assign ex_o  = sub_i ? {W{went_negative}} : {{(W-1){1'b0}}, carry_out};
endmodule

// File: rtl/ex_alu_mul.sv
module ex_alu_mul #(
  parameter int W = 16
) (
  input  logic         signed_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] b_x, a_x, prod;

  // Extending both operands to full product width makes the low 2W bits
  // of an unsigned multiply correct for either signedness.
  assign b_x  = {{W{signed_i & b_i[W-1]}}, b_i};
  assign a_x  = {{W{signed_i & a_i[W-1]}}, a_i};
  assign prod = b_x * a_x;

  assign lo_o = prod[W-1:0];
  assign hi_o = prod[PW-1:W];
endmodule

// File: rtl/ex_alu_divmod.sv
module ex_alu_divmod #(
  parameter int W = 16
) (
  input  logic         signed_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] frac_o,
  output logic [W-1:0] rem_o
);
  localparam int DW = 2 * W + 2;

  logic signed [DW-1:0] b_x, a_x, q_w, f_w, r_w;
  logic                 div_by_zero;
  logic [3*(DW-W)-1:0]  unused_high;

  assign b_x = {{(DW-W){signed_i & b_i[W-1]}}, b_i};
  assign a_x = {{(DW-W){signed_i & a_i[W-1]}}, a_i};
  assign div_by_zero = (a_i == '0);

  // Signed division truncates toward zero; zero-extended values stay positive.
  always_comb begin
    if (div_by_zero) begin
      q_w = '0;
      f_w = '0;
      r_w = '0;
    end else begin
      q_w = b_x / a_x;
      f_w = (b_x <<< W) / a_x;
      r_w = b_x % a_x;
    end
  end

  assign quo_o  = q_w[W-1:0];
  assign frac_o = f_w[W-1:0];
  assign rem_o  = r_w[W-1:0];
  assign unused_high = {q_w[DW-1:W], f_w[DW-1:W], r_w[DW-1:W]};
endmodule

// File: rtl/ex_alu_shift.sv
module ex_alu_shift #(
  parameter int W = 16
) (
  input  logic [1:0]   kind_i,   // 01 logical right, 10 arithmetic right, 11 left
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] amt_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] ex_o
);
  localparam int XW = 2 * W;

  logic        [XW-1:0] w_srl, w_sll;
  logic signed [XW-1:0] w_sra;

  // One double-width shift per kind yields both the result and the bits
  // carried into the other half.
  assign w_srl = {b_i, {W{1'b0}}} >> amt_i;
  assign w_sra = $signed({b_i, {W{1'b0}}}) >>> amt_i;
  assign w_sll = {{W{1'b0}}, b_i} << amt_i;

  always_comb begin
    case (kind_i)
      2'b01:   begin res_o = w_srl[XW-1:W]; ex_o = w_srl[W-1:0];  end
      2'b10:   begin res_o = w_sra[XW-1:W]; ex_o = w_sra[W-1:0];  end
      2'b11:   begin res_o = w_sll[W-1:0];  ex_o = w_sll[XW-1:W]; end
      default: begin res_o = '0;            ex_o = '0;            end
    endcase
  end
endmodule

// File: rtl/ex_alu_cmp.sv
module ex_alu_cmp #(
  parameter int W = 16
) (
  input  logic [2:0]   sel_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] a_i,
  output logic         hit_o
);
  always_comb begin
    case (sel_i)
      3'd0: hit_o = |(b_i & a_i);
      3'd1: hit_o = ~|(b_i & a_i);
      3'd2: hit_o = (b_i == a_i);
      3'd3: hit_o = (b_i != a_i);
      3'd4: hit_o = (b_i > a_i);
      3'd5: hit_o = ($signed(b_i) > $signed(a_i));
      3'd6: hit_o = (b_i < a_i);
      default: hit_o = ($signed(b_i) < $signed(a_i));
    endcase
  end
endmodule

// File: rtl/ex_alu16.sv
module ex_alu16
  import ex_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_i,
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   a_i,
  output logic [W-1:0]   res_o,
  output logic [W-1:0]   ex_next_o,
  output logic           ex_we_o,
  output logic           cond_o,
  output logic [W-1:0]   ex_o
);
  logic [W-1:0] ex_q;
  logic [W-1:0] as_res, as_ex, mul_lo, mul_hi, dv_quo, dv_frac, dv_rem, sh_res, sh_ex;
  logic         cmp_hit;
  logic         as_sub, as_use_ex, mul_signed, dv_signed;

  assign as_sub     = (op_i == OP_SUB)  || (op_i == OP_SUBX);
  assign as_use_ex  = (op_i == OP_ADDX) || (op_i == OP_SUBX);
  assign mul_signed = (op_i == OP_MULS);
  assign dv_signed  = (op_i == OP_DIVS) || (op_i == OP_REMS);

  ex_alu_addsub #(.W(W)) u_addsub (
    .sub_i(as_sub), .use_ex_i(as_use_ex), .b_i(b_i), .a_i(a_i), .ex_i(ex_q),
    .res_o(as_res), .ex_o(as_ex)
  );

  ex_alu_mul #(.W(W)) u_mul (
    .signed_i(mul_signed), .b_i(b_i), .a_i(a_i), .lo_o(mul_lo), .hi_o(mul_hi)
  );

  ex_alu_divmod #(.W(W)) u_divmod (
    .signed_i(dv_signed), .b_i(b_i), .a_i(a_i),
    .quo_o(dv_quo), .frac_o(dv_frac), .rem_o(dv_rem)
  );

  ex_alu_shift #(.W(W)) u_shift (
    .kind_i(op_i[1:0]), .b_i(b_i), .amt_i(a_i), .res_o(sh_res), .ex_o(sh_ex)
  );

  ex_alu_cmp #(.W(W)) u_cmp (
    .sel_i(op_i[2:0]), .b_i(b_i), .a_i(a_i), .hit_o(cmp_hit)
  );

  always_comb begin
    res_o     = b_i;
    ex_next_o = ex_q;
    case (op_i)
      OP_ADD, OP_SUB, OP_ADDX, OP_SUBX: begin res_o = as_res; ex_next_o = as_ex;   end
      OP_MULU, OP_MULS:                 begin res_o = mul_lo; ex_next_o = mul_hi;  end
      OP_DIVU, OP_DIVS:                 begin res_o = dv_quo; ex_next_o = dv_frac; end
      OP_REMU, OP_REMS:                 res_o = dv_rem;
      OP_AND:                           res_o = b_i & a_i;
      OP_OR:                            res_o = b_i | a_i;
      OP_XOR:                           res_o = b_i ^ a_i;
      OP_SRL, OP_SRA, OP_SLL:           begin res_o = sh_res; ex_next_o = sh_ex;   end
      OP_COPY, OP_COPY_UP, OP_COPY_DN:  res_o = a_i;
      default:                          res_o = b_i;
    endcase
  end

  assign ex_we_o = exec_i & op_writes_ex(op_i);
  assign cond_o  = op_is_compare(op_i) & cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ex_q <= '0;
    else if (ex_we_o) ex_q <= ex_next_o;
  end

  assign ex_o = ex_q;

  // R11: EX captures the offered value on an enabled edge
  a_r11_ex_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ex_we_o |=> (ex_o == $past(ex_next_o)));

  // R11: EX holds when not enabled
  a_r11_ex_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_we_o |=> $stable(ex_o));

  // R2: add carry word is 0 or 1, subtract borrow word is 0 or all ones
  a_r2_add_ex_range: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADD) |-> (ex_next_o == '0 || ex_next_o == W'(1)));

  a_r2_sub_ex_range: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SUB) |-> (ex_next_o == '0 || ex_next_o == '1));

  // R4: divide by zero zeroes both quotient and fraction
  a_r4_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_DIVU || op_i == OP_DIVS) && a_i == '0) |-> (res_o == '0 && ex_next_o == '0));

  // R5: unsigned remainder stays below a nonzero divisor
  a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_REMU && a_i != '0) |-> (res_o < a_i));

  // R6: bitwise codes never enable the EX write
  a_r6_logic_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |-> !ex_we_o);

  // R7: logical shifts by at least twice the width clear both halves
  a_r7_wide_shift_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_SRL || op_i == OP_SLL) && a_i >= W'(2*W)) |-> (res_o == '0 && ex_next_o == '0));

  // R10: unassigned codes pass b and leave EX alone
  a_r10_pass_b: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'h18 || op_i == 5'h19 || op_i == 5'h1C || op_i == 5'h1D || op_i == 5'h00)
      |-> (res_o == b_i && !ex_we_o));
endmodule

// File: tb/ex_alu16_bench.sv
`timescale 1ns/1ps
module ex_alu16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_r = 1'b0;
  logic [4:0]  op_r = '0;
  logic [15:0] b_r = '0, a_r = '0;
  logic [15:0] res_o, ex_next_o, ex_o;
  logic        ex_we_o, cond_o;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ex_alu16 u_ex_alu16 (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_r), .op_i(op_r), .b_i(b_r), .a_i(a_r),
    .res_o(res_o), .ex_next_o(ex_next_o), .ex_we_o(ex_we_o), .cond_o(cond_o), .ex_o(ex_o)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] b;
    logic [15:0] a;
    logic [15:0] res;
    logic        we;
    logic [15:0] ex;
    logic        cond;
  } vec_t;

  // Expected values assume EX = 0 before each vector.
  localparam int NV = 37;
  localparam vec_t VT [NV] = '{
    '{5'h02, 16'hFFFF, 16'h0002, 16'h0001, 1'b1, 16'h0001, 1'b0},
    '{5'h02, 16'h1234, 16'h1111, 16'h2345, 1'b1, 16'h0000, 1'b0},
    '{5'h03, 16'h0001, 16'h0002, 16'hFFFF, 1'b1, 16'hFFFF, 1'b0},
    '{5'h03, 16'h0005, 16'h0003, 16'h0002, 1'b1, 16'h0000, 1'b0},
    '{5'h04, 16'hFFFF, 16'hFFFF, 16'h0001, 1'b1, 16'hFFFE, 1'b0},
    '{5'h05, 16'hFFFF, 16'h0002, 16'hFFFE, 1'b1, 16'hFFFF, 1'b0},
    '{5'h06, 16'h0007, 16'h0002, 16'h0003, 1'b1, 16'h8000, 1'b0},
    '{5'h06, 16'h1234, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0},
    '{5'h07, 16'hFFF9, 16'h0002, 16'hFFFD, 1'b1, 16'h8000, 1'b0},
    '{5'h08, 16'h0007, 16'h0003, 16'h0001, 1'b0, 16'h0000, 1'b0},
    '{5'h08, 16'h0005, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
    '{5'h09, 16'hFFF9, 16'h0003, 16'hFFFF, 1'b0, 16'h0000, 1'b0},
    '{5'h0A, 16'hF0F0, 16'hFF00, 16'hF000, 1'b0, 16'h0000, 1'b0},
    '{5'h0B, 16'hF0F0, 16'h0F00, 16'hFFF0, 1'b0, 16'h0000, 1'b0},
    '{5'h0C, 16'hF0F0, 16'hFF00, 16'h0FF0, 1'b0, 16'h0000, 1'b0},
    '{5'h0D, 16'h8001, 16'h0004, 16'h0800, 1'b1, 16'h1000, 1'b0},
    '{5'h0D, 16'h8001, 16'h0010, 16'h0000, 1'b1, 16'h8001, 1'b0},
    '{5'h0E, 16'h8001, 16'h0004, 16'hF800, 1'b1, 16'h1000, 1'b0},
    '{5'h0E, 16'h8000, 16'h0014, 16'hFFFF, 1'b1, 16'hF800, 1'b0},
    '{5'h0F, 16'h8001, 16'h0004, 16'h0010, 1'b1, 16'h0008, 1'b0},
    '{5'h0F, 16'h0001, 16'h0014, 16'h0000, 1'b1, 16'h0010, 1'b0},
    '{5'h0F, 16'hFFFF, 16'h0028, 16'h0000, 1'b1, 16'h0000, 1'b0},
    '{5'h10, 16'h00F0, 16'h0F00, 16'h00F0, 1'b0, 16'h0000, 1'b0},
    '{5'h11, 16'h00F0, 16'h0F00, 16'h00F0, 1'b0, 16'h0000, 1'b1},
    '{5'h12, 16'h1234, 16'h1234, 16'h1234, 1'b0, 16'h0000, 1'b1},
    '{5'h13, 16'h1234, 16'h1234, 16'h1234, 1'b0, 16'h0000, 1'b0},
    '{5'h14, 16'h8000, 16'h7FFF, 16'h8000, 1'b0, 16'h0000, 1'b1},
    '{5'h15, 16'h8000, 16'h7FFF, 16'h8000, 1'b0, 16'h0000, 1'b0},
    '{5'h16, 16'h8000, 16'h7FFF, 16'h8000, 1'b0, 16'h0000, 1'b0},
    '{5'h17, 16'h8000, 16'h7FFF, 16'h8000, 1'b0, 16'h0000, 1'b1},
    '{5'h1A, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 16'h0001, 1'b0},
    '{5'h1B, 16'h0000, 16'h0001, 16'hFFFF, 1'b1, 16'hFFFF, 1'b0},
    '{5'h18, 16'hABCD, 16'h1111, 16'hABCD, 1'b0, 16'h0000, 1'b0},
    '{5'h00, 16'hABCD, 16'h1111, 16'hABCD, 1'b0, 16'h0000, 1'b0},
    '{5'h1C, 16'hABCD, 16'h1111, 16'hABCD, 1'b0, 16'h0000, 1'b0},
    '{5'h01, 16'hABCD, 16'h1111, 16'h1111, 1'b0, 16'h0000, 1'b0},
    '{5'h1F, 16'hABCD, 16'h1111, 16'h1111, 1'b0, 16'h0000, 1'b0}
  };

  function automatic string tag_of(logic [4:0] op);
    if (op == 5'h02 || op == 5'h03) return "R2";
    if (op == 5'h04 || op == 5'h05) return "R3";
    if (op == 5'h06 || op == 5'h07) return "R4";
    if (op == 5'h08 || op == 5'h09) return "R5";
    if (op >= 5'h0A && op <= 5'h0C) return "R6";
    if (op >= 5'h0D && op <= 5'h0F) return "R7";
    if (op >= 5'h10 && op <= 5'h17) return "R9";
    if (op == 5'h1A || op == 5'h1B) return "R8";
    return "R10";
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Comb outputs sampled 1 ns after the falling-edge drive; EX 1 ns after the rising edge.
  task automatic run(input string tag, input logic [4:0] op, input logic [15:0] b, input logic [15:0] a,
                     input logic [15:0] er, input logic ew, input logic [15:0] ex_after, input logic ec);
    @(negedge clk);
    op_r = op; b_r = b; a_r = a; exec_r = 1'b1;
    #1;
    check(tag, "result", res_o, er);
    check(tag, "cond", {15'b0, cond_o}, {15'b0, ec});
    check(tag, "ex_we", {15'b0, ex_we_o}, {15'b0, ew});
    if (ew) check(tag, "ex_next", ex_next_o, ex_after);
    @(posedge clk);
    #1;
    exec_r = 1'b0;
    check(tag, "ex", ex_o, ex_after);
  endtask

  task automatic preset_ex(input logic [15:0] v);
    if (v == 16'h0000)      run("R11 preset0", 5'h03, 16'h0000, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0);
    else if (v == 16'h0001) run("R11 preset1", 5'h02, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 16'h0001, 1'b0);
    else                    run("R11 presetF", 5'h03, 16'h0000, 16'h0001, 16'hFFFF, 1'b1, 16'hFFFF, 1'b0);
  endtask

  initial begin
    // R1: reset state
    #1;
    check("R1", "ex in reset", ex_o, 16'h0000);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "ex after reset", ex_o, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      preset_ex(16'h0000);
      run(tag_of(VT[i].op), VT[i].op, VT[i].b, VT[i].a, VT[i].res, VT[i].we, VT[i].ex, VT[i].cond);
    end

    // R11: without the strobe the write is not enabled and EX holds
    @(negedge clk);
    op_r = 5'h02; b_r = 16'hFFFF; a_r = 16'h0001; exec_r = 1'b0;
    #1;
    check("R11", "we without exec", {15'b0, ex_we_o}, 16'h0000);
    check("R11", "ex_next without exec", ex_next_o, 16'h0001);
    @(posedge clk);
    #1;
    check("R11", "ex held without exec", ex_o, 16'h0000);

    // R8: carry-in forms using a nonzero EX
    preset_ex(16'h0001);
    run("R8", 5'h1A, 16'h0001, 16'h0002, 16'h0004, 1'b1, 16'h0000, 1'b0);
    preset_ex(16'h0001);
    run("R8", 5'h1A, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 16'h0001, 1'b0);
    preset_ex(16'h0001);
    run("R8", 5'h1B, 16'h0000, 16'h0002, 16'hFFFF, 1'b1, 16'hFFFF, 1'b0);
    preset_ex(16'hFFFF);
    run("R8", 5'h1B, 16'h0005, 16'h0001, 16'h0003, 1'b1, 16'h0000, 1'b0);

    // R6, R5, R10, R9: EX stays at a nonzero value through non-writing codes
    preset_ex(16'h0001);
    run("R6", 5'h0C, 16'h1234, 16'h00FF, 16'h12CB, 1'b0, 16'h0001, 1'b0);
    run("R5", 5'h08, 16'h0064, 16'h0007, 16'h0002, 1'b0, 16'h0001, 1'b0);
    run("R10", 5'h19, 16'h5A5A, 16'h0001, 16'h5A5A, 1'b0, 16'h0001, 1'b0);
    run("R10", 5'h1E, 16'h5A5A, 16'h0042, 16'h0042, 1'b0, 16'h0001, 1'b0);
    run("R9", 5'h10, 16'h0180, 16'h0100, 16'h0180, 1'b0, 16'h0001, 1'b1);
    run("R3", 5'h05, 16'h8000, 16'h8000, 16'h0000, 1'b1, 16'h4000, 1'b0);
    run("R4", 5'h07, 16'h8000, 16'hFFFF, 16'h8000, 1'b1, 16'h0000, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule